// File: doc/BRIEF.md
# Codec Serial Data-In Steering Router

This block decides how a set of codec serial data-in lines (three by default) reach two input channel pairs. Pair 1 and pair 2 each carry a PCM channel and a microphone channel. Software controls the routing through an 8-bit map register on a simple host register bus. With steering off, every data-in line is OR-merged onto pair 1, and pair 2 is reported as unavailable. With steering on, each pair takes its data from one line, chosen by its own 2-bit select field.

The block also records which data-in line returned the data for the most recent codec register read. A read-complete strobe from the link logic carries the line index. A second 8-bit register is a codec-access semaphore. A host read of it returns the current state and sets the bit in the same access. An access-done pulse from the link logic clears it.

Host reads are combinational: `reg_rdata` shows the addressed register's value in the same cycle that `reg_rd` is high. Any side effect of the read takes effect at the next rising clock edge.

Top module: `sdin_steer_top`

## Requirements
- R1: After synchronous active-low reset:
  - both registers read 00h;
  - `set1_avail` is 1 and `set2_avail` is 0.
- R2: The map register fields are:
  - bits 7:6 hold the pair 2 select;
  - bits 5:4 hold the pair 1 select;
  - bit 3 is steer enable;
  - bit 2 always reads 0;
  - bits 1:0 cannot be written by the host.
- R3: When steer enable is 0:
  - `set1_sdin` equals the OR of all data-in lines;
  - `set2_sdin` is 0 and `set2_avail` is 0, whatever the pair 2 select holds.
- R4: When steer enable is 1, a pair whose select is 00, 01 or 10 follows data-in line 0, 1 or 2 respectively.
- R5: When steer enable is 1, a pair whose select is 11 (reserved) outputs a constant 0 and its availability output is 0.
- R6: The availability outputs are:
  - `set2_avail` = steer enable AND (pair 2 select ≠ 11);
  - `set1_avail` is 1 unless steering is on with pair 1 select = 11.
- R7: Map bits 1:0 take `rd_line` on a cycle with `rd_done` high and `rd_line` in 0–2, using the same encoding as the selects. On every other cycle they keep their value, including a `rd_done` whose `rd_line` is 11.
- R8: A read of the semaphore register returns the bit value from before the read, in bit 0, with bits 7:1 at 0. The read leaves the bit at 1. A read while the bit is already 1 returns 1.
- R9: An `acc_done` pulse clears the semaphore bit. If a semaphore read falls in the same cycle, the read wins and the bit stays 1.
- R10: A host write to the semaphore register has no effect on its state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 8 | Host register address (map at 10h, semaphore at 14h) |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, valid in the cycle `reg_rd` is high, 0 otherwise |
| sdin | input | 3 | Codec serial data-in lines, bit n is line n |
| rd_done | input | 1 | Codec register read completed (stub) |
| rd_line | input | 2 | Data-in line index that carried that read's data |
| acc_done | input | 1 | Codec access completed (stub) |
| set1_sdin | output | 1 | Serial input routed to the pair 1 channels |
| set2_sdin | output | 1 | Serial input routed to the pair 2 channels |
| set1_avail | output | 1 | Pair 1 channels available |
| set2_avail | output | 1 | Pair 2 channels available |

## Verification
The routing outputs are swept over all eight data-in patterns in each of three settings:
- merged mode with a nonzero pair 2 select, which shows that an OR is used rather than a single line and that the pair 2 field is ignored;
- steered mode with the two pairs on different lines, which would expose swapped or misindexed selects;
- the reserved select on both pairs, which separates a forced 0 from a leaked line.

The last-read capture is driven with valid indices, the reserved index and idle cycles, to show both update and hold. The semaphore is read in its cleared and set states, with and without a coincident `acc_done`, and after a host write. A long seeded random run then mixes all of these patterns.

// File: rtl/sdin_steer_pkg.sv
// Shared types for the codec data-in steering block.
// Assumes two channel pairs and 2-bit line select fields.
package sdin_steer_pkg;
    localparam int SEL_W   = 2;
    localparam int NUM_SET = 2;

    // Writable part of the map register, bit 7 down to bit 3.
    typedef struct packed {
        logic [SEL_W-1:0] sel2;
        logic [SEL_W-1:0] sel1;
        logic             steer;
    } map_cfg_t;
endpackage

// File: rtl/sdin_map_reg.sv
// Map register: holds the steering configuration and the last-read line index.
// Assumes NUM_LINES <= 3, so that select code 11 is always reserved.
module sdin_map_reg
    import sdin_steer_pkg::*;
#(
    parameter int NUM_LINES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [4:0]       wfield,
    input  logic             rd_done,
    input  logic [SEL_W-1:0] rd_line,
    output map_cfg_t         cfg,
    output logic [SEL_W-1:0] last_line
);
    localparam logic [SEL_W-1:0] LINE_LIMIT = SEL_W'(NUM_LINES);

    // Store the host-writable configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (wr_en)
            cfg <= map_cfg_t'(wfield);
    end

    // Capture the line that returned the last codec read, valid indices only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_line <= '0;
        else if (rd_done && (rd_line < LINE_LIMIT))
            last_line <= rd_line;
    end
endmodule

// File: rtl/sdin_sema.sv
// Codec access semaphore: a read sets the flag, access-done clears it.
// Assumes the read strobe already carries the address decode; the read has priority.
module sdin_sema (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_hit,
    input  logic acc_done,
    output logic flag
);
    // Set on a read, clear on access-done, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (rd_hit)
            flag <= 1'b1;
        else if (acc_done)
            flag <= 1'b0;
    end
endmodule

// File: rtl/sdin_router.sv
// Combinational router: sends the data-in lines to the channel pairs and reports availability.
// Assumes NUM_LINES <= 3. Pair index 0 is pair 1, index 1 is pair 2.
module sdin_router
    import sdin_steer_pkg::*;
#(
    parameter int NUM_LINES = 3
) (
    input  map_cfg_t             cfg,
    input  logic [NUM_LINES-1:0] sdin,
    output logic [NUM_SET-1:0]   set_sdin,
    output logic [NUM_SET-1:0]   set_avail
);
    localparam logic [SEL_W-1:0] LINE_LIMIT = SEL_W'(NUM_LINES);

    logic [SEL_W-1:0] sel [NUM_SET];
    logic             merged;

    // Unpack the per-pair select fields and merge all lines.
    always_comb begin
        sel[0] = cfg.sel1;
        sel[1] = cfg.sel2;
        merged = |sdin;
    end

    for (genvar g = 0; g < NUM_SET; g++) begin : g_set
        logic picked;
        logic valid;

        // Choose the selected line, or the merged signal when not steered.
        always_comb begin
            picked = 1'b0;
            for (int i = 0; i < NUM_LINES; i++)
                if (sel[g] == SEL_W'(i))
                    picked = sdin[i];
            valid = sel[g] < LINE_LIMIT;
            if (cfg.steer) begin
                set_sdin[g]  = picked & valid;
                set_avail[g] = valid;
            end else begin
                set_sdin[g]  = (g == 0) ? merged : 1'b0;
                set_avail[g] = (g == 0);
            end
        end
    end
endmodule

// File: rtl/sdin_steer_top.sv
// Top of the codec data-in steering block: host register decode, map register,
// semaphore and router. Assumes single-cycle host strobes and combinational read data.
module sdin_steer_top
    import sdin_steer_pkg::*;
#(
    parameter int          NUM_LINES = 3,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  MAP_ADDR  = 8'h10,
    parameter logic [7:0]  SEM_ADDR  = 8'h14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic [NUM_LINES-1:0] sdin,
    input  logic                 rd_done,
    input  logic [SEL_W-1:0]     rd_line,
    input  logic                 acc_done,
    output logic                 set1_sdin,
    output logic                 set2_sdin,
    output logic                 set1_avail,
    output logic                 set2_avail
);
    localparam logic [ADDR_W-1:0] MAP_A = ADDR_W'(MAP_ADDR);
    localparam logic [ADDR_W-1:0] SEM_A = ADDR_W'(SEM_ADDR);

    map_cfg_t           cfg;
    logic [SEL_W-1:0]   last_line;
    logic               sem_q;
    logic               map_sel;
    logic               sem_sel;
    logic [NUM_SET-1:0] set_sdin;
    logic [NUM_SET-1:0] set_avail;

    // Decode which register the host is addressing.
    always_comb begin
        map_sel = (reg_addr == MAP_A);
        sem_sel = (reg_addr == SEM_A);
    end

    sdin_map_reg #(.NUM_LINES(NUM_LINES)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr && map_sel),
        .wfield    (reg_wdata[7:3]),
        .rd_done   (rd_done),
        .rd_line   (rd_line),
        .cfg       (cfg),
        .last_line (last_line)
    );

    sdin_sema u_sema (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_hit   (reg_rd && sem_sel),
        .acc_done (acc_done),
        .flag     (sem_q)
    );

    sdin_router #(.NUM_LINES(NUM_LINES)) u_route (
        .cfg       (cfg),
        .sdin      (sdin),
        .set_sdin  (set_sdin),
        .set_avail (set_avail)
    );

    // Map router outputs to the named pair ports.
    always_comb begin
        set1_sdin  = set_sdin[0];
        set2_sdin  = set_sdin[1];
        set1_avail = set_avail[0];
        set2_avail = set_avail[1];
    end

    // Return the addressed register during a host read, 0 otherwise.
    always_comb begin
        reg_rdata = 8'h00;
        if (reg_rd && map_sel)
            reg_rdata = {cfg, 1'b0, last_line};
        else if (reg_rd && sem_sel)
            reg_rdata = {7'b0, sem_q};
    end
endmodule

// File: rtl/sdin_steer_chk.sv
// Assertion checker for sdin_steer_top, attached with bind below.
// Assumes it observes the top's ports and its internal configuration and state.
module sdin_steer_chk
    import sdin_steer_pkg::*;
#(
    parameter int         NUM_LINES = 3,
    parameter int         ADDR_W    = 8,
    parameter logic [7:0] SEM_ADDR  = 8'h14
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_rd,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [NUM_LINES-1:0] sdin,
    input logic                 rd_done,
    input logic                 acc_done,
    input logic                 set1_sdin,
    input logic                 set2_sdin,
    input logic                 set1_avail,
    input logic                 set2_avail,
    input map_cfg_t             cfg,
    input logic [SEL_W-1:0]     last_line,
    input logic                 sem_q
);
    logic sem_rd;
    always_comb sem_rd = reg_rd && (reg_addr == ADDR_W'(SEM_ADDR));

    a_r3_merge_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.steer |-> (set1_sdin == (|sdin)) && !set2_sdin && !set2_avail);

    a_r4_set1_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.steer && cfg.sel1 == 2'd1) |-> (set1_sdin == sdin[1]));

    a_r5_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.steer && cfg.sel2 == 2'd3) |-> (!set2_sdin && !set2_avail));

    a_r6_set1_avail: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg.steer && cfg.sel1 == 2'd3) |-> set1_avail);

    a_r7_last_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done |=> $stable(last_line));

    a_r8_read_sets: assert property (@(posedge clk) disable iff (!rst_n)
        sem_rd |=> sem_q);

    a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done && !sem_rd) |=> !sem_q);
endmodule

bind sdin_steer_top sdin_steer_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .SEM_ADDR  (SEM_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .sdin       (sdin),
    .rd_done    (rd_done),
    .acc_done   (acc_done),
    .set1_sdin  (set1_sdin),
    .set2_sdin  (set2_sdin),
    .set1_avail (set1_avail),
    .set2_avail (set2_avail),
    .cfg        (cfg),
    .last_line  (last_line),
    .sem_q      (sem_q)
);

// File: tb/sdin_steer_top_test.sv
// Testbench for sdin_steer_top: directed corners followed by seeded random traffic.
module sdin_steer_top_test;
    localparam logic [7:0] MAP_A = 8'h10;
    localparam logic [7:0] SEM_A = 8'h14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [2:0] sdin = 3'b000;
    logic       rd_done = 1'b0, acc_done = 1'b0;
    logic [1:0] rd_line = 2'd0;
    logic       set1_sdin, set2_sdin, set1_avail, set2_avail;

    int checks = 0;
    int fails = 0;

    // Reference state of the registers.
    logic [1:0] m_sel1 = 0, m_sel2 = 0, m_last = 0;
    logic       m_steer = 0, m_sem = 0;
    logic [7:0] rd_got;

    always #2 clk = ~clk;

    sdin_steer_top uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sdin(sdin), .rd_done(rd_done), .rd_line(rd_line), .acc_done(acc_done),
        .set1_sdin(set1_sdin), .set2_sdin(set2_sdin),
        .set1_avail(set1_avail), .set2_avail(set2_avail)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic pick(input logic [2:0] sd, input logic [1:0] s);
        return (s == 2'd3) ? 1'b0 : sd[s];
    endfunction

    function automatic string route_tag(input logic [1:0] s);
        if (!m_steer) return "R3";
        return (s == 2'd3) ? "R5" : "R4";
    endfunction

    // Check outputs for the driven inputs, clock once, update the model, clear strobes.
    task automatic step();
        logic e1, e2, a1, a2;
        #1;
        e1 = m_steer ? pick(sdin, m_sel1) : |sdin;
        e2 = m_steer ? pick(sdin, m_sel2) : 1'b0;
        a1 = !(m_steer && m_sel1 == 2'd3);
        a2 = m_steer && (m_sel2 != 2'd3);
        chk(route_tag(m_sel1), {7'b0, set1_sdin}, {7'b0, e1});
        chk(route_tag(m_sel2), {7'b0, set2_sdin}, {7'b0, e2});
        chk("R6", {6'b0, set2_avail, set1_avail}, {6'b0, a2, a1});
        rd_got = reg_rdata;
        if (reg_rd && reg_addr == MAP_A)
            chk("R2", reg_rdata, {m_sel2, m_sel1, m_steer, 1'b0, m_last});
        else if (reg_rd && reg_addr == SEM_A)
            chk("R8", reg_rdata, {7'b0, m_sem});
        @(posedge clk);
        if (reg_wr && reg_addr == MAP_A) begin
            m_sel2  = reg_wdata[7:6];
            m_sel1  = reg_wdata[5:4];
            m_steer = reg_wdata[3];
        end
        if (rd_done && rd_line != 2'd3) m_last = rd_line;
        if (reg_rd && reg_addr == SEM_A) m_sem = 1'b1;
        else if (acc_done) m_sem = 1'b0;
        #1;
        reg_wr = 0; reg_rd = 0; rd_done = 0; acc_done = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step();
    endtask

    task automatic rd(input logic [7:0] a);
        reg_rd = 1; reg_addr = a;
        step();
    endtask

    task automatic sweep();
        for (int p = 0; p < 8; p++) begin
            sdin = 3'(p);
            step();
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values, read while still in reset
        reg_rd = 1; reg_addr = MAP_A; #1;
        chk("R1", reg_rdata, 8'h00);
        reg_addr = SEM_A; #1;
        chk("R1", reg_rdata, 8'h00);
        chk("R1", {6'b0, set2_avail, set1_avail}, 8'h01);
        reg_rd = 0;
        @(posedge clk); #1;
        rst_n = 1;

        // R3: merged mode, pair 2 select nonzero but ignored
        wr(MAP_A, 8'b10_01_0_000);
        sweep();
        // R4: steered onto distinct lines
        wr(MAP_A, 8'b10_01_1_000);
        sweep();
        wr(MAP_A, 8'b00_10_1_000);
        sweep();
        // R5: reserved code on both pairs
        wr(MAP_A, 8'b11_11_1_000);
        sweep();
        chk("R5", {6'b0, set2_avail, set1_avail}, 8'h00);

        // R2: bit 2 reads 0 and bits 1:0 are not writable
        wr(MAP_A, 8'hFF);
        rd(MAP_A);
        chk("R2", rd_got, 8'hF8);

        // R7: capture valid index, hold on reserved index and idle cycles
        rd_done = 1; rd_line = 2'd2; step();
        rd(MAP_A);
        chk("R7", rd_got & 8'h03, 8'h02);
        rd_done = 1; rd_line = 2'd3; step();
        step();
        rd(MAP_A);
        chk("R7", rd_got & 8'h03, 8'h02);
        rd_done = 1; rd_line = 2'd1; step();
        rd(MAP_A);
        chk("R7", rd_got & 8'h03, 8'h01);

        // R8: first read returns 0, second read returns 1
        rd(SEM_A);
        chk("R8", rd_got, 8'h00);
        rd(SEM_A);
        chk("R8", rd_got, 8'h01);
        // R9: done clears; done together with a read keeps the bit set
        acc_done = 1; step();
        acc_done = 1; rd(SEM_A);
        chk("R9", rd_got, 8'h00);
        rd(SEM_A);
        chk("R9", rd_got, 8'h01);
        // R10: a host write cannot change the semaphore
        acc_done = 1; step();
        wr(SEM_A, 8'hFF);
        rd(SEM_A);
        chk("R10", rd_got, 8'h00);
        wr(SEM_A, 8'h00);
        rd(SEM_A);
        chk("R10", rd_got, 8'h01);

        // Seeded random traffic, checked against the model in every step
        for (int n = 0; n < 3000; n++) begin
            sdin = 3'($urandom);
            if ($urandom % 5 == 0) begin
                reg_wr = 1;
                reg_addr = ($urandom % 2) ? MAP_A : SEM_A;
                reg_wdata = 8'($urandom);
            end else if ($urandom % 3 == 0) begin
                reg_rd = 1;
                reg_addr = ($urandom % 2) ? MAP_A : SEM_A;
            end
            rd_done = ($urandom % 4 == 0);
            rd_line = 2'($urandom);
            acc_done = ($urandom % 4 == 0);
            step();
        end
        finish_run();
    end
endmodule